// File: doc/BRIEF.md
# Spanning Tree Port Forwarding Filter

This block sits between the address lookup stage and the frame queues of a small multi-port switch. For every frame it takes the ingress port number, the destination port set produced by lookup, and flags from the lookup and receive logic. From these and the per-port spanning tree controls it decides which destinations the frame may reach, and whether the source address may be learned. Each normal port has three control bits: transmit allowed, receive allowed and learning off. One fixed port connects to the management processor. That port is never gated, so spanning tree control traffic always has a path.

The five spanning tree states are encoded with the three bits. In forwarding, transmit is 1, receive is 1 and learning off is 0. In learning, all three bits are 0. In disabled, blocking and listening, transmit and receive are 0 and learning off is 1. A frame that arrives on a receive-gated port is discarded unless it hit a static table entry that carries the override flag. In that case it is redirected to the processor port alone. The processor can still reach a transmit-gated port with a frame that it marks as explicitly directed. The decision is registered once, so the result appears one clock after the frame is presented.

Top module: `stp_port_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fwd_valid`, `fwd_dest` and `fwd_learn` are all 0.
- R2: `fwd_valid` equals `frm_valid` of the previous clock. When `fwd_valid` is 0, `fwd_dest` and `fwd_learn` are 0.
- R3: For a source port whose receive bit is 1, `fwd_dest` is the lookup set `frm_dest` with only transmit-gated normal ports removed. When all ports are in forwarding (tx 1, rx 1, learn-off 0), the set passes unchanged. `fwd_dest` is never outside `frm_dest` plus the processor bit.
- R4: A frame from a normal port whose receive bit is 0 and whose `frm_trap` is 0 is discarded: `fwd_dest` is 0.
- R5: A frame from a normal port whose receive bit is 0 and whose `frm_trap` is 1 gets `fwd_dest` equal to the processor bit only (bit `HOST_PORT`, default 4). When the receive bit is 1, `frm_trap` has no effect.
- R6: A destination normal port with transmit bit 0 is removed from the set, except when the source is the processor port and `frm_host_direct` is 1.
- R7: The processor port bit in `frm_dest` is always kept for an accepted frame. The processor port's own transmit and receive bits have no effect.
- R8: `fwd_learn` is 1 exactly when the frame is valid, its source is in range, `frm_bad` is 0 and the source port's learning-off bit is 0. Receive gating does not suppress learning, so the learning state learns while discarding the frame.
- R9: A frame with `frm_bad` set gets `fwd_dest` 0 and `fwd_learn` 0.
- R10: A source number at or above `NUM_PORTS` (5 to 7 at default size) gives `fwd_dest` 0 and `fwd_learn` 0.
- R11: `frm_host_direct` has no effect when the source is not the processor port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_en | input | NUM_PORTS | Per-port transmit allowed bit |
| cfg_rx_en | input | NUM_PORTS | Per-port receive allowed bit |
| cfg_learn_off | input | NUM_PORTS | Per-port learning-off bit |
| frm_valid | input | 1 | A frame decision is requested this cycle |
| frm_src | input | SRC_W | Ingress port number |
| frm_dest | input | NUM_PORTS | Destination set from address lookup, bit n is port n |
| frm_trap | input | 1 | Static table hit with override flag |
| frm_host_direct | input | 1 | Processor frame explicitly aimed at its destination |
| frm_bad | input | 1 | Frame flagged bad by the receive logic |
| fwd_valid | output | 1 | Decision valid, one clock after `frm_valid` |
| fwd_dest | output | NUM_PORTS | Filtered destination set |
| fwd_learn | output | 1 | Source address may be learned |

## Verification
The hardest case to reach is a frame that meets several gates at once. One example is a trapped frame from a receive-gated port that is in the learning state. It must be redirected to the processor and still learn. Another is a processor frame aimed at a transmit-gated port, where the direct flag decides the result. The directed steps set up each port state combination explicitly and pair each gated case with a control case that differs in one bit. A long stream then draws random configurations, sources (including out-of-range numbers) and flags on every clock. This stream reaches the mixed cases the directed steps do not list.

// File: rtl/stp_filter_pkg.sv
package stp_filter_pkg;

  // How an accepted or rejected frame is routed through the filter
  typedef enum logic [1:0] {
    PATH_DROP     = 2'd0,
    PATH_HOST_SRC = 2'd1,
    PATH_PASS     = 2'd2,
    PATH_TRAP     = 2'd3
  } path_e;

  // Order of tests encodes priority: bad/out-of-range first, then the
  // ungated processor source, then receive gating with its override.
  function automatic path_e pick_path(input logic src_ok, input logic bad,
                                      input logic host_src, input logic rx_ok,
                                      input logic trap);
    if (!src_ok || bad) return PATH_DROP;
    if (host_src)       return PATH_HOST_SRC;
    if (rx_ok)          return PATH_PASS;
    if (trap)           return PATH_TRAP;
    return PATH_DROP;
  endfunction

  // Whether a destination bit survives transmit gating
  function automatic logic dest_kept(input logic want, input logic is_host,
                                     input logic tx_ok, input logic host_src,
                                     input logic host_direct);
    return want & (is_host | tx_ok | (host_src & host_direct));
  endfunction

endpackage

// File: rtl/stp_ingress_gate.sv
module stp_ingress_gate #(
  parameter int NUM_PORTS = 5,
  parameter int HOST_PORT = 4,
  parameter int SRC_W     = 3
) (
  input  logic [SRC_W-1:0]     frm_src,
  input  logic [NUM_PORTS-1:0] cfg_rx_en,
  output logic                 src_ok,
  output logic                 host_src,
  output logic                 rx_ok
);
  localparam int SPAN = 1 << SRC_W;

  logic [SPAN-1:0] rx_pad;

  assign rx_pad   = SPAN'(cfg_rx_en);
  assign src_ok   = 32'(frm_src) < NUM_PORTS;
  assign host_src = src_ok && (32'(frm_src) == HOST_PORT);
  assign rx_ok    = src_ok && rx_pad[frm_src];
endmodule

// File: rtl/stp_egress_gate.sv
module stp_egress_gate
  import stp_filter_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int HOST_PORT = 4
) (
  input  logic [NUM_PORTS-1:0] frm_dest,
  input  logic [NUM_PORTS-1:0] cfg_tx_en,
  input  logic                 host_src,
  input  logic                 host_direct,
  output logic [NUM_PORTS-1:0] keep
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic IS_HOST = (p == HOST_PORT);
    assign keep[p] = dest_kept(frm_dest[p], IS_HOST, cfg_tx_en[p],
                               host_src, host_direct);
  end
endmodule

// File: rtl/stp_learn_gate.sv
module stp_learn_gate #(
  parameter int NUM_PORTS = 5,
  parameter int SRC_W     = 3
) (
  input  logic                 frm_valid,
  input  logic                 src_ok,
  input  logic                 frm_bad,
  input  logic [SRC_W-1:0]     frm_src,
  input  logic [NUM_PORTS-1:0] cfg_learn_off,
  output logic                 learn
);
  localparam int SPAN = 1 << SRC_W;

  logic [SPAN-1:0] off_pad;

  assign off_pad = SPAN'(cfg_learn_off);
  assign learn   = frm_valid && src_ok && !frm_bad && !off_pad[frm_src];
endmodule

// File: rtl/stp_port_filter.sv
module stp_port_filter
  import stp_filter_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int HOST_PORT = 4,
  parameter int SRC_W     = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] cfg_tx_en,
  input  logic [NUM_PORTS-1:0] cfg_rx_en,
  input  logic [NUM_PORTS-1:0] cfg_learn_off,
  input  logic                 frm_valid,
  input  logic [SRC_W-1:0]     frm_src,
  input  logic [NUM_PORTS-1:0] frm_dest,
  input  logic                 frm_trap,
  input  logic                 frm_host_direct,
  input  logic                 frm_bad,
  output logic                 fwd_valid,
  output logic [NUM_PORTS-1:0] fwd_dest,
  output logic                 fwd_learn
);
  localparam logic [NUM_PORTS-1:0] HOST_BIT = NUM_PORTS'(1) << HOST_PORT;

  // Named internal events, used by the bound checker
  logic                 src_ok;
  logic                 host_src;
  logic                 rx_ok;
  logic [NUM_PORTS-1:0] keep_mask;
  logic                 learn_now;
  logic                 trap_taken;
  path_e                path;
  logic [NUM_PORTS-1:0] dest_nxt;

  stp_ingress_gate #(
    .NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT), .SRC_W(SRC_W)
  ) u_ingress (
    .frm_src  (frm_src),
    .cfg_rx_en(cfg_rx_en),
    .src_ok   (src_ok),
    .host_src (host_src),
    .rx_ok    (rx_ok)
  );

  stp_egress_gate #(
    .NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT)
  ) u_egress (
    .frm_dest   (frm_dest),
    .cfg_tx_en  (cfg_tx_en),
    .host_src   (host_src),
    .host_direct(frm_host_direct),
    .keep       (keep_mask)
  );

  stp_learn_gate #(
    .NUM_PORTS(NUM_PORTS), .SRC_W(SRC_W)
  ) u_learn (
    .frm_valid    (frm_valid),
    .src_ok       (src_ok),
    .frm_bad      (frm_bad),
    .frm_src      (frm_src),
    .cfg_learn_off(cfg_learn_off),
    .learn        (learn_now)
  );

  assign path       = pick_path(src_ok, frm_bad, host_src, rx_ok, frm_trap);
  assign trap_taken = frm_valid && (path == PATH_TRAP);

  always_comb begin
    dest_nxt = '0;
    if (frm_valid) begin
      unique case (path)
        PATH_HOST_SRC, PATH_PASS: dest_nxt = keep_mask;
        PATH_TRAP:                dest_nxt = HOST_BIT;
        default:                  dest_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_dest  <= '0;
      fwd_learn <= 1'b0;
    end else begin
      fwd_valid <= frm_valid;
      fwd_dest  <= dest_nxt;
      fwd_learn <= learn_now;
    end
  end
endmodule

// File: rtl/stp_port_filter_chk.sv
module stp_port_filter_chk #(
  parameter int NUM_PORTS = 5,
  parameter int HOST_PORT = 4,
  parameter int SRC_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] cfg_tx_en,
  input logic [NUM_PORTS-1:0] cfg_rx_en,
  input logic [NUM_PORTS-1:0] cfg_learn_off,
  input logic                 frm_valid,
  input logic [SRC_W-1:0]     frm_src,
  input logic [NUM_PORTS-1:0] frm_dest,
  input logic                 frm_trap,
  input logic                 frm_host_direct,
  input logic                 frm_bad,
  input logic                 fwd_valid,
  input logic [NUM_PORTS-1:0] fwd_dest,
  input logic                 fwd_learn,
  input logic                 host_src,
  input logic [NUM_PORTS-1:0] keep_mask,
  input logic                 trap_taken
);
  localparam int SPAN = 1 << SRC_W;
  localparam logic [NUM_PORTS-1:0] HOST_BIT = NUM_PORTS'(1) << HOST_PORT;

  logic [SPAN-1:0] rx_pad, off_pad;
  logic in_range, normal_src, rx_here, off_here;

  assign rx_pad     = SPAN'(cfg_rx_en);
  assign off_pad    = SPAN'(cfg_learn_off);
  assign in_range   = 32'(frm_src) < NUM_PORTS;
  assign normal_src = in_range && (32'(frm_src) != HOST_PORT);
  assign rx_here    = rx_pad[frm_src];
  assign off_here   = off_pad[frm_src];

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> fwd_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> (!fwd_valid && fwd_dest == '0 && !fwd_learn));
  assert_dest_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> ((fwd_dest & ~($past(frm_dest) | HOST_BIT)) == '0));
  assert_rx_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && normal_src && !rx_here && !frm_trap && !frm_bad) |=> fwd_dest == '0);
  assert_trap_to_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> fwd_dest == HOST_BIT);
  assert_trap_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (normal_src && !rx_here && frm_trap));
  assert_tx_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((keep_mask & ~cfg_tx_en & ~HOST_BIT) != '0) |-> (host_src && frm_host_direct));
  assert_host_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && in_range && !frm_bad && (!normal_src || rx_here) && frm_dest[HOST_PORT])
    |=> fwd_dest[HOST_PORT]);
  assert_learn_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && off_here) |=> !fwd_learn);
  assert_bad_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_bad) |=> (fwd_dest == '0 && !fwd_learn));
  assert_src_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !in_range) |=> (fwd_dest == '0 && !fwd_learn));
endmodule

bind stp_port_filter stp_port_filter_chk #(
  .NUM_PORTS(NUM_PORTS), .HOST_PORT(HOST_PORT), .SRC_W(SRC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
  .cfg_learn_off(cfg_learn_off), .frm_valid(frm_valid), .frm_src(frm_src),
  .frm_dest(frm_dest), .frm_trap(frm_trap), .frm_host_direct(frm_host_direct),
  .frm_bad(frm_bad), .fwd_valid(fwd_valid), .fwd_dest(fwd_dest),
  .fwd_learn(fwd_learn), .host_src(host_src), .keep_mask(keep_mask),
  .trap_taken(trap_taken)
);

// File: tb/tb_stp_port_filter.sv
module tb_stp_port_filter;
  localparam int NP   = 5;
  localparam int HOST = 4;
  localparam int SW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] tx = '1, rx = '1, off = '0;
  logic          v = 1'b0, trap = 1'b0, direct = 1'b0, bad = 1'b0;
  logic [SW-1:0] src = '0;
  logic [NP-1:0] dest = '0;
  logic          o_valid, o_learn;
  logic [NP-1:0] o_dest;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  stp_port_filter #(.NUM_PORTS(NP), .HOST_PORT(HOST)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_tx_en(tx), .cfg_rx_en(rx),
    .cfg_learn_off(off), .frm_valid(v), .frm_src(src), .frm_dest(dest),
    .frm_trap(trap), .frm_host_direct(direct), .frm_bad(bad),
    .fwd_valid(o_valid), .fwd_dest(o_dest), .fwd_learn(o_learn)
  );

  // Behavioural reference: walks the requirements as plain decisions
  task automatic model(output logic ev, output logic [NP-1:0] ed, output logic el);
    int s;
    s  = int'(src);
    ev = v;
    ed = '0;
    el = 1'b0;
    if (!v) return;
    if (s >= NP || bad) return;
    el = !off[s];
    if (s != HOST && !rx[s]) begin
      if (trap) ed[HOST] = 1'b1;
      return;
    end
    for (int p = 0; p < NP; p++) begin
      if (!dest[p]) continue;
      if (p == HOST || tx[p] || (s == HOST && direct)) ed[p] = 1'b1;
    end
  endtask

  task automatic compare(input string tag, input logic ev,
                         input logic [NP-1:0] ed, input logic el);
    n_checks++;
    if (o_valid !== ev || o_dest !== ed || o_learn !== el) begin
      n_fail++;
      $display("FAIL %s: got valid=%b dest=%b learn=%b, expected valid=%b dest=%b learn=%b",
               tag, o_valid, o_dest, o_learn, ev, ed, el);
    end
  endtask

  // Called at a falling edge: drive, then check one clock later
  task automatic apply(input string tag, input logic vv, input int s,
                       input logic [NP-1:0] d, input logic tr,
                       input logic di, input logic bd);
    logic ev, el;
    logic [NP-1:0] ed;
    v = vv; src = SW'(s); dest = d; trap = tr; direct = di; bad = bd;
    model(ev, ed, el);
    @(negedge clk);
    compare(tag, ev, ed, el);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset", 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 1'b0, '0, 1'b0);

    // All forwarding
    apply("R3 forwarding src0", 1, 0, 5'b11110, 0, 0, 0);
    apply("R3 forwarding src1", 1, 1, 5'b11101, 0, 0, 0);
    apply("R5 trap ignored when rx on", 1, 0, 5'b00110, 1, 0, 0);
    apply("R2 idle cycle", 0, 0, 5'b11111, 0, 0, 0);

    // Port 2 blocking: tx0 rx0 off1
    tx[2] = 0; rx[2] = 0; off[2] = 1;
    apply("R4 blocking discard", 1, 2, 5'b10001, 0, 0, 0);
    apply("R5 blocking trap to host", 1, 2, 5'b00001, 1, 0, 0);
    // Port 2 learning: tx0 rx0 off0
    off[2] = 0;
    apply("R8 learning state learns", 1, 2, 5'b10001, 0, 0, 0);
    apply("R5 R8 learning trap", 1, 2, 5'b00011, 1, 0, 0);

    // Port 3 transmit gated
    tx = '1; rx = '1; off = '0; tx[3] = 0;
    apply("R6 tx gated dest removed", 1, 0, 5'b01110, 0, 0, 0);
    apply("R6 host direct reaches gated", 1, HOST, 5'b01000, 0, 1, 0);
    apply("R6 host undirected blocked", 1, HOST, 5'b01000, 0, 0, 0);
    apply("R11 direct ignored off host", 1, 0, 5'b01000, 0, 1, 0);

    // Host port own bits cleared
    tx = '1; rx = '1; tx[HOST] = 0; rx[HOST] = 0;
    apply("R7 host src ungated", 1, HOST, 5'b00001, 0, 0, 0);
    apply("R7 host dest kept", 1, 0, 5'b10000, 0, 0, 0);
    rx[1] = 0;
    apply("R7 host dest on gated src", 1, 1, 5'b10000, 0, 0, 0);

    off[0] = 1;
    apply("R8 learning off", 1, 0, 5'b00010, 0, 0, 0);
    apply("R9 bad frame", 1, 1, 5'b00101, 0, 0, 1);
    apply("R10 source 6", 1, 6, 5'b11111, 1, 1, 0);
    apply("R10 source 5", 1, 5, 5'b00011, 0, 0, 0);

    // Mixed stream, compared every clock
    for (int i = 0; i < 400; i++) begin
      tx  = NP'($urandom);
      rx  = NP'($urandom);
      off = NP'($urandom);
      apply("MIX stream", 1'($urandom % 5 != 0), int'($urandom % 8),
            NP'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 6 == 0));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule